// File: doc/BRIEF.md
# Processor Operating-Mode Controller

This block holds the architectural control state that decides how a processor core forms addresses. Three control registers feed it: the main control word with its protection and paging enables, the page-table base register, and the feature register with the physical-address-extension enable. A separate 64-bit model-specific register space sits beside them, addressed by 32 bits, and holds the extended-feature register. From this state the block drives the current operating mode and each enable bit as a level, for the rest of the core to use.

Software reaches long mode only through a fixed order of steps. Protection comes on first, with paging still off. Then address extension is enabled, then a page-table base is loaded, then the long-mode enable is set in the extended-feature register. Last, paging is turned on. The block checks every write against that order. A write that breaks the order leaves all state unchanged and raises a one-cycle error flag. Model-specific register data moves as two 32-bit halves, and reads return their halves one cycle after the request.

Top module: `cpu_mode_ctl`

## Requirements
- R1: After reset all enables are 0, `cpu_mode` is 0 (real), `pt_base` is 0, and `ctl_err`, `msr_rvalid` and both read halves are 0.
- R2: A write to control index 0 takes bit 0 as the protection enable and bit 31 as the paging enable. `cpu_mode` encodes 0 real, 1 protected, 2 protected with paging, 3 long, and shows the new value in the cycle after the write.
- R3: A control-index-0 write that sets bit 31 while bit 0 is clear is rejected: no state changes and `ctl_err` pulses.
- R4: A write to control index 3 loads `pt_base` with the written word with its low 12 bits cleared.
- R5: A write to control index 4 takes bit 5 as the address-extension enable. Clearing it while long-mode enable is set is rejected with `ctl_err`.
- R6: The extended-feature register sits at MSR address 0xC0000080. A read returns long-mode enable at bit 8 and long-mode active at bit 10 of the low half, with the high half 0. A write ignores bit 10, and a write with any other bit set apart from bit 8 (either half) is rejected with `ctl_err`.
- R7: Setting long-mode enable is accepted only while protection is on, paging is off, address extension is on, and a control-index-3 write has occurred since reset. Otherwise it is rejected with `ctl_err`.
- R8: Any change of long-mode enable while paging is on is rejected with `ctl_err`. The same change is accepted once paging is off.
- R9: `long_mode_active` rises, and `cpu_mode` becomes 3, only on an accepted write that turns paging on while long-mode enable is set. It falls when paging is turned off.
- R10: An MSR request to any other address changes nothing and pulses `ctl_err`. A read there still gives `msr_rvalid` with both halves 0.
- R11: A control write to an index other than 0, 3 or 4 changes nothing and pulses `ctl_err`.
- R12: When a control write and an MSR request arrive in the same cycle, the control write is handled normally. The MSR request is rejected: a read returns zero halves and `ctl_err` pulses.
- R13: `ctl_err` is high for exactly the one cycle after a rejected command and low after an accepted or idle cycle. `msr_rvalid` is high only in the cycle after a read request, and the read halves are 0 whenever it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_idx | input | 3 | Control-register index (0, 3, 4 valid) |
| cr_wdata | input | 32 | Control-register write data |
| msr_req | input | 1 | MSR command strobe |
| msr_wr | input | 1 | 1 write, 0 read |
| msr_addr | input | 32 | MSR address |
| msr_wdata_lo | input | 32 | MSR write data, bits 31:0 |
| msr_wdata_hi | input | 32 | MSR write data, bits 63:32 |
| msr_rvalid | output | 1 | Read data valid, one cycle after a read request |
| msr_rdata_lo | output | 32 | MSR read data, bits 31:0 |
| msr_rdata_hi | output | 32 | MSR read data, bits 63:32 |
| ctl_err | output | 1 | One-cycle pulse for a rejected command |
| cpu_mode | output | 2 | Operating mode encoding |
| prot_en | output | 1 | Protection enabled |
| paging_en | output | 1 | Paging enabled |
| addr_ext_en | output | 1 | Address extension enabled |
| long_mode_en | output | 1 | Long-mode enable held in the extended-feature register |
| long_mode_active | output | 1 | Long mode in effect |
| pt_base | output | 32 | Top-level page-table base |

## Verification
Every enable is a port driven straight from a register, so a wrong internal bit shows up in the cycle right after the write that caused it. The sole exception is the flag that records a loaded page-table base. A wrong value there stays hidden until a later attempt to set long-mode enable, which then succeeds or fails against the expected result. The bench runs every ordering rule from both sides, the illegal attempt and the legal one, with a reference model that is compared on every clock. A wrong gating term therefore shows up as an error pulse, or a missing one, one cycle after the command.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;

    localparam int CR_W   = 32;
    localparam int HALF_W = 32;

    typedef enum logic [1:0] {
        MODE_REAL  = 2'd0,
        MODE_PROT  = 2'd1,
        MODE_PAGED = 2'd2,
        MODE_LONG  = 2'd3
    } cpu_mode_e;

    // architectural control state
    typedef struct packed {
        logic            pe;
        logic            pg;
        logic            pae;
        logic            lme;
        logic            lma;
        logic            base_loaded;
        logic [CR_W-1:0] pt_base;
    } arch_t;

    // full registered state of the controller
    typedef struct packed {
        arch_t             arch;
        logic              err;
        logic              rvalid;
        logic [HALF_W-1:0] rd_lo;
        logic [HALF_W-1:0] rd_hi;
    } ctl_state_t;

endpackage

// File: rtl/cr_write_check.sv
module cr_write_check
    import mode_ctl_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int PE_BIT     = 0,
    parameter int PG_BIT     = 31,
    parameter int PAE_BIT    = 5,
    parameter int PAGE_SHIFT = 12
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [CR_W-1:0]  wdata,
    input  arch_t            cur,
    output arch_t            nxt,
    output logic             bad
);
    localparam logic [CR_W-1:0] OFFS_MASK = CR_W'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [IDX_W-1:0] IDX_MAIN = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_FEAT = IDX_W'(4);

    always_comb begin
        nxt = cur;
        bad = 1'b0;
        if (wr_en) begin
            case (idx)
                IDX_MAIN: begin
                    // paging without protection is illegal
                    if (wdata[PG_BIT] && !wdata[PE_BIT]) begin
                        bad = 1'b1;
                    end else begin
                        nxt.pe  = wdata[PE_BIT];
                        nxt.pg  = wdata[PG_BIT];
                        nxt.lma = wdata[PG_BIT] && cur.lme;
                    end
                end
                IDX_BASE: begin
                    nxt.pt_base     = wdata & ~OFFS_MASK;
                    nxt.base_loaded = 1'b1;
                end
                IDX_FEAT: begin
                    // address extension is locked while long mode is enabled
                    if (!wdata[PAE_BIT] && cur.lme) begin
                        bad = 1'b1;
                    end else begin
                        nxt.pae = wdata[PAE_BIT];
                    end
                end
                default: bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/msr_access.sv
module msr_access
    import mode_ctl_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] EFER_ADDR = ADDR_W'(32'hC000_0080),
    parameter int              LME_BIT   = 8,
    parameter int              LMA_BIT   = 10
) (
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wlo,
    input  logic [HALF_W-1:0] whi,
    input  logic              blocked,
    input  logic              pe,
    input  logic              pg,
    input  logic              pae,
    input  logic              lme,
    input  logic              lma,
    input  logic              base_loaded,
    output logic              lme_nx,
    output logic              bad,
    output logic              rvalid,
    output logic [HALF_W-1:0] rd_lo,
    output logic [HALF_W-1:0] rd_hi
);
    localparam logic [HALF_W-1:0] LME_M  = HALF_W'(1) << LME_BIT;
    localparam logic [HALF_W-1:0] LMA_M  = HALF_W'(1) << LMA_BIT;
    localparam logic [HALF_W-1:0] KEEP_M = LME_M | LMA_M;

    logic hit;
    logic want;
    logic resv;
    logic ready;

    assign hit   = (addr == EFER_ADDR);
    assign want  = wlo[LME_BIT];
    assign resv  = (|(wlo & ~KEEP_M)) || (|whi);
    assign ready = pe && !pg && pae && base_loaded;

    always_comb begin
        lme_nx = lme;
        bad    = 1'b0;
        rvalid = req && !wr;
        rd_lo  = '0;
        rd_hi  = '0;
        if (req) begin
            if (blocked || !hit) begin
                bad = 1'b1;
            end else if (!wr) begin
                rd_lo = (lme ? LME_M : '0) | (lma ? LMA_M : '0);
            end else if (resv) begin
                bad = 1'b1;
            end else if ((want != lme) && pg) begin
                bad = 1'b1;
            end else if (want && !lme && !ready) begin
                bad = 1'b1;
            end else begin
                lme_nx = want;
            end
        end
    end

endmodule

// File: rtl/cpu_mode_ctl.sv
module cpu_mode_ctl
    import mode_ctl_pkg::*;
#(
    parameter int              IDX_W      = 3,
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] EFER_ADDR  = ADDR_W'(32'hC000_0080),
    parameter int              PE_BIT     = 0,
    parameter int              PG_BIT     = 31,
    parameter int              PAE_BIT    = 5,
    parameter int              LME_BIT    = 8,
    parameter int              LMA_BIT    = 10,
    parameter int              PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_wr_en,
    input  logic [IDX_W-1:0]  cr_idx,
    input  logic [CR_W-1:0]   cr_wdata,
    input  logic              msr_req,
    input  logic              msr_wr,
    input  logic [ADDR_W-1:0] msr_addr,
    input  logic [HALF_W-1:0] msr_wdata_lo,
    input  logic [HALF_W-1:0] msr_wdata_hi,
    output logic              msr_rvalid,
    output logic [HALF_W-1:0] msr_rdata_lo,
    output logic [HALF_W-1:0] msr_rdata_hi,
    output logic              ctl_err,
    output logic [1:0]        cpu_mode,
    output logic              prot_en,
    output logic              paging_en,
    output logic              addr_ext_en,
    output logic              long_mode_en,
    output logic              long_mode_active,
    output logic [CR_W-1:0]   pt_base
);
    ctl_state_t st_q, st_d;
    arch_t      cr_nxt;
    logic       cr_bad;
    logic       msr_lme_nx;
    logic       msr_bad;
    logic       msr_rv;
    logic [HALF_W-1:0] msr_lo, msr_hi;
    cpu_mode_e  mode_now;

    cr_write_check #(
        .IDX_W     (IDX_W),
        .PE_BIT    (PE_BIT),
        .PG_BIT    (PG_BIT),
        .PAE_BIT   (PAE_BIT),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) i_cr_check (
        .wr_en(cr_wr_en),
        .idx  (cr_idx),
        .wdata(cr_wdata),
        .cur  (st_q.arch),
        .nxt  (cr_nxt),
        .bad  (cr_bad)
    );

    msr_access #(
        .ADDR_W   (ADDR_W),
        .EFER_ADDR(EFER_ADDR),
        .LME_BIT  (LME_BIT),
        .LMA_BIT  (LMA_BIT)
    ) i_msr (
        .req        (msr_req),
        .wr         (msr_wr),
        .addr       (msr_addr),
        .wlo        (msr_wdata_lo),
        .whi        (msr_wdata_hi),
        .blocked    (cr_wr_en),
        .pe         (st_q.arch.pe),
        .pg         (st_q.arch.pg),
        .pae        (st_q.arch.pae),
        .lme        (st_q.arch.lme),
        .lma        (st_q.arch.lma),
        .base_loaded(st_q.arch.base_loaded),
        .lme_nx     (msr_lme_nx),
        .bad        (msr_bad),
        .rvalid     (msr_rv),
        .rd_lo      (msr_lo),
        .rd_hi      (msr_hi)
    );

    // next-state: an MSR update is blocked whenever a control write is present,
    // so the two paths never modify the same cycle's state together
    always_comb begin
        st_d          = st_q;
        st_d.arch     = cr_nxt;
        st_d.arch.lme = cr_wr_en ? cr_nxt.lme : msr_lme_nx;
        st_d.err      = cr_bad || msr_bad;
        st_d.rvalid   = msr_rv;
        st_d.rd_lo    = msr_lo;
        st_d.rd_hi    = msr_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.arch.lma)      mode_now = MODE_LONG;
        else if (st_q.arch.pg)  mode_now = MODE_PAGED;
        else if (st_q.arch.pe)  mode_now = MODE_PROT;
        else                    mode_now = MODE_REAL;
    end

    assign cpu_mode         = mode_now;
    assign prot_en          = st_q.arch.pe;
    assign paging_en        = st_q.arch.pg;
    assign addr_ext_en      = st_q.arch.pae;
    assign long_mode_en     = st_q.arch.lme;
    assign long_mode_active = st_q.arch.lma;
    assign pt_base          = st_q.arch.pt_base;
    assign ctl_err          = st_q.err;
    assign msr_rvalid       = st_q.rvalid;
    assign msr_rdata_lo     = st_q.rd_lo;
    assign msr_rdata_hi     = st_q.rd_hi;

    // R3: paging never held without protection
    assert_pg_needs_pe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        paging_en |-> prot_en);

    // R5: long-mode enable never held without address extension
    assert_lme_needs_pae_R5: assert property (@(posedge clk) disable iff (!rst_n)
        long_mode_en |-> addr_ext_en);

    // R9: long mode active implies its enables and the long encoding
    assert_lma_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        long_mode_active |-> (paging_en && long_mode_en && cpu_mode == MODE_LONG));

    // R8: long-mode enable frozen across cycles where paging stays on
    assert_lme_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (paging_en && $past(paging_en)) |-> $stable(long_mode_en));

    // R10: every read request is answered the next cycle
    assert_read_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_req && !msr_wr) |=> msr_rvalid);

    // R10: unimplemented address always flags
    assert_bad_addr_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_req && msr_addr != EFER_ADDR) |=> ctl_err);

    // R11: unknown control index always flags
    assert_bad_idx_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en && cr_idx != IDX_W'(0) && cr_idx != IDX_W'(3) && cr_idx != IDX_W'(4))
        |=> ctl_err);

    // R13: read data is zero whenever not valid
    assert_rdata_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rvalid |-> (msr_rdata_lo == '0 && msr_rdata_hi == '0));

endmodule

// File: tb/test_cpu_mode_ctl.sv
`timescale 1ns/1ps
module test_cpu_mode_ctl;

    localparam logic [31:0] EFER = 32'hC000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_wr_en = 1'b0;
    logic [2:0]  cr_idx = '0;
    logic [31:0] cr_wdata = '0;
    logic        msr_req = 1'b0;
    logic        msr_wr = 1'b0;
    logic [31:0] msr_addr = '0;
    logic [31:0] msr_wdata_lo = '0;
    logic [31:0] msr_wdata_hi = '0;
    logic        msr_rvalid;
    logic [31:0] msr_rdata_lo, msr_rdata_hi;
    logic        ctl_err;
    logic [1:0]  cpu_mode;
    logic        prot_en, paging_en, addr_ext_en, long_mode_en, long_mode_active;
    logic [31:0] pt_base;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";
    string mdl_tag = "R1";

    always #4 clk = ~clk;

    cpu_mode_ctl i_cpu_mode_ctl (
        .clk(clk), .rst_n(rst_n),
        .cr_wr_en(cr_wr_en), .cr_idx(cr_idx), .cr_wdata(cr_wdata),
        .msr_req(msr_req), .msr_wr(msr_wr), .msr_addr(msr_addr),
        .msr_wdata_lo(msr_wdata_lo), .msr_wdata_hi(msr_wdata_hi),
        .msr_rvalid(msr_rvalid), .msr_rdata_lo(msr_rdata_lo), .msr_rdata_hi(msr_rdata_hi),
        .ctl_err(ctl_err), .cpu_mode(cpu_mode),
        .prot_en(prot_en), .paging_en(paging_en), .addr_ext_en(addr_ext_en),
        .long_mode_en(long_mode_en), .long_mode_active(long_mode_active),
        .pt_base(pt_base)
    );

    // behavioural reference model
    bit          m_pe, m_pg, m_pae, m_lme, m_lma, m_loaded, m_err, m_rv;
    logic [31:0] m_base = '0, m_lo = '0, m_hi = '0;

    always @(posedge clk) begin
        bit e, want, resv;
        mdl_tag = cur_req;
        if (!rst_n) begin
            m_pe = 0; m_pg = 0; m_pae = 0; m_lme = 0; m_lma = 0; m_loaded = 0;
            m_err = 0; m_rv = 0; m_base = '0; m_lo = '0; m_hi = '0;
        end else begin
            e = 0; m_rv = 0; m_lo = '0; m_hi = '0;
            if (msr_req) begin
                if (!msr_wr) m_rv = 1;
                if (cr_wr_en || msr_addr != EFER) e = 1;
                else if (!msr_wr) m_lo = (m_lme ? 32'h100 : 32'h0) | (m_lma ? 32'h400 : 32'h0);
                else begin
                    want = msr_wdata_lo[8];
                    resv = ((msr_wdata_lo & ~32'h500) != 0) || (msr_wdata_hi != 0);
                    if (resv) e = 1;
                    else if (want != m_lme && m_pg) e = 1;
                    else if (want && !m_lme && !(m_pe && !m_pg && m_pae && m_loaded)) e = 1;
                    else m_lme = want;
                end
            end
            if (cr_wr_en) begin
                if (cr_idx == 0) begin
                    if (cr_wdata[31] && !cr_wdata[0]) e = 1;
                    else begin
                        m_pe = cr_wdata[0]; m_pg = cr_wdata[31]; m_lma = m_pg && m_lme;
                    end
                end else if (cr_idx == 3) begin
                    m_base = cr_wdata & 32'hFFFF_F000; m_loaded = 1;
                end else if (cr_idx == 4) begin
                    if (!cr_wdata[5] && m_lme) e = 1;
                    else m_pae = cr_wdata[5];
                end else e = 1;
            end
            m_err = e;
        end
    end

    function automatic logic [1:0] exp_mode();
        if (m_lma) return 2'd3;
        if (m_pg) return 2'd2;
        if (m_pe) return 2'd1;
        return 2'd0;
    endfunction

    // full-port comparison on every clock
    always @(negedge clk) begin
        logic [104:0] act, exp;
        act = {cpu_mode, prot_en, paging_en, addr_ext_en, long_mode_en, long_mode_active,
               ctl_err, msr_rvalid, pt_base, msr_rdata_lo, msr_rdata_hi};
        exp = {exp_mode(), m_pe, m_pg, m_pae, m_lme, m_lma,
               m_err, m_rv, m_base, m_lo, m_hi};
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: ports act=%h exp=%h", mdl_tag, act, exp);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit ce, input logic [2:0] ix, input logic [31:0] d,
                         input bit mr, input bit mw, input logic [31:0] a,
                         input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        cr_wr_en = ce; cr_idx = ix; cr_wdata = d;
        msr_req = mr; msr_wr = mw; msr_addr = a; msr_wdata_lo = lo; msr_wdata_hi = hi;
        @(negedge clk);
        cr_wr_en = 0; msr_req = 0; msr_wr = 0;
    endtask

    task automatic crw(input logic [2:0] ix, input logic [31:0] d);
        drive(1, ix, d, 0, 0, '0, '0, '0);
    endtask

    task automatic msw(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
        drive(0, '0, '0, 1, 1, a, lo, hi);
    endtask

    task automatic msr_rd(input logic [31:0] a);
        drive(0, '0, '0, 1, 0, a, '0, '0);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check("R1", {30'd0, cpu_mode}, 32'd0);
        check("R1", pt_base, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R11"; crw(3'd2, 32'h1);
        check("R11", {31'd0, ctl_err}, 32'd1);
        cur_req = "R3";  crw(3'd0, 32'h8000_0000);
        check("R3", {31'd0, paging_en}, 32'd0);
        cur_req = "R7";  msw(EFER, 32'h100, 0);
        cur_req = "R2";  crw(3'd0, 32'h1);
        check("R2", {30'd0, cpu_mode}, 32'd1);
        cur_req = "R7";  msw(EFER, 32'h100, 0);
        cur_req = "R5";  crw(3'd4, 32'h20);
        cur_req = "R7";  msw(EFER, 32'h100, 0);
        check("R7", {31'd0, long_mode_en}, 32'd0);
        cur_req = "R4";  crw(3'd3, 32'h1234_5ABC);
        check("R4", pt_base, 32'h1234_5000);
        cur_req = "R6";  msr_rd(EFER);
        msw(EFER, 32'h101, 0);
        msw(EFER, 32'h100, 32'h1);
        cur_req = "R7";  msw(EFER, 32'h500, 0);
        check("R7", {31'd0, long_mode_en}, 32'd1);
        cur_req = "R6";  msr_rd(EFER);
        check("R6", msr_rdata_lo, 32'h100);
        cur_req = "R5";  crw(3'd4, 32'h0);
        cur_req = "R9";  crw(3'd0, 32'h8000_0001);
        check("R9", {30'd0, cpu_mode}, 32'd3);
        cur_req = "R6";  msr_rd(EFER);
        check("R6", msr_rdata_lo, 32'h500);
        cur_req = "R8";  msw(EFER, 32'h0, 0);
        check("R8", {31'd0, long_mode_en}, 32'd1);
        cur_req = "R10"; msr_rd(EFER + 1);
        check("R10", msr_rdata_lo, 32'd0);
        msw(32'h10, 32'h100, 0);
        cur_req = "R12"; drive(1, 3'd3, 32'h0000_2FFF, 1, 0, EFER, '0, '0);
        check("R12", pt_base, 32'h0000_2000);
        check("R12", {31'd0, ctl_err}, 32'd1);
        cur_req = "R13"; crw(3'd7, 32'h0);
        crw(3'd0, 32'h8000_0001);
        check("R13", {31'd0, ctl_err}, 32'd0);
        cur_req = "R9";  crw(3'd0, 32'h1);
        check("R9", {31'd0, long_mode_active}, 32'd0);
        cur_req = "R8";  msw(EFER, 32'h0, 0);
        check("R8", {31'd0, long_mode_en}, 32'd0);
        cur_req = "R2";  crw(3'd0, 32'h8000_0001);
        check("R2", {30'd0, cpu_mode}, 32'd2);
        cur_req = "R13"; repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule